// File: doc/BRIEF.md
# Periodic Motor Update Scheduler

This block decides when the drive levels prepared for a set of motor channels are copied into the registers that actually feed the output stage. A millisecond tick advances an interval counter; each time the count reaches the programmed interval, the pending levels are published. A one-shot force request publishes at once, outside the periodic rhythm. An interval of zero turns periodic publishing off, so that only force requests move the outputs.

A global enable byte switches the driver enable output. A fault pulse starts the failsafe reaction. Depending on a five-bit control word, the reaction holds the active levels or clears them to zero drive. It can also emit a restart request (reboot or re-enumerate) and reinit requests for the user port and the expansion port, and it increments a saturating fault counter. PWM generation lives downstream and is not part of this block.

Top module: `motor_update_sched`

## Requirements
- R1: With a non-zero interval N, the active levels take the pending levels at the clock edge that samples the N-th tick counted since the previous refresh. Between refreshes the active levels do not change.
- R2: With an interval of 0, ticks never cause a refresh.
- R3: A force pulse loads the active levels at the edge that samples it. The request is not remembered afterwards. A force also restarts the tick count, and a force that falls on a periodic refresh gives a single refresh.
- R4: The enable output is high one cycle after the enable byte equals 0x01 and low for every other value. While it is low, refreshes still update the active levels.
- R5: Failsafe control bit 0 picks the reaction to a fault pulse. With bit 0 clear, the levels are left untouched. With bit 0 set, every active level is zero one cycle later, even if a refresh happens in the same cycle. A later refresh loads pending levels again.
- R6: Failsafe control bits 2:1 select the restart request on a fault: 1 gives a one-cycle reboot pulse, 2 gives a one-cycle re-enumerate pulse, and 0 or 3 give no pulse.
- R7: On a fault, failsafe control bit 3 gives a one-cycle user-port reinit pulse and bit 4 gives a one-cycle expansion-port reinit pulse. Without a fault, no request pulse ever appears.
- R8: Each fault pulse adds one to the fault counter, which saturates at its all-ones value.
- R9: After reset, the active levels, enable, request pulses, fault counter and tick count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| interval_i | input | IVL_W | Refresh interval in ticks, 0 = force only |
| force_upd_i | input | 1 | One-cycle force refresh request |
| drv_enable_i | input | 8 | Enable byte, 0x01 = drivers on |
| fs_ctrl_i | input | 5 | Failsafe control: bit0 zero, bits2:1 restart, bit3 user reinit, bit4 expansion reinit |
| fault_i | input | 1 | One-cycle failsafe event |
| pend_lvl_i | input | NUM_CH*LVL_W | Pending drive levels, channel 0 in the low bits |
| act_lvl_o | output | NUM_CH*LVL_W | Active drive levels |
| drv_en_o | output | 1 | Driver enable |
| reboot_req_o | output | 1 | Reboot request pulse |
| reenum_req_o | output | 1 | Re-enumerate request pulse |
| user_reinit_o | output | 1 | User-port reinit pulse |
| exp_reinit_o | output | 1 | Expansion-port reinit pulse |
| fault_cnt_o | output | FCNT_W | Saturating fault count |

## Verification
The bench builds the block with three 8-bit channels, an 8-bit interval and a 3-bit fault counter. The narrow counter makes saturation reachable after seven faults. Intervals of 3 and 4 keep each periodic window to a few ticks, so a force in the middle of a window can be told apart from one that does not restart the count. Three distinct per-channel patterns catch lanes that are swapped or left stale.

// File: rtl/mus_pkg.sv
package mus_pkg;

  // Restart action selected by failsafe control bits 2:1
  typedef enum logic [1:0] {
    RST_NONE   = 2'd0,
    RST_REBOOT = 2'd1,
    RST_REENUM = 2'd2,
    RST_RSVD   = 2'd3
  } restart_e;

  // Failsafe control word; field positions are decoded by the reaction unit
  typedef struct packed {
    logic     exp_reinit;   // bit 4
    logic     user_reinit;  // bit 3
    restart_e restart;      // bits 2:1
    logic     zero_out;     // bit 0
  } fs_ctrl_t;

  localparam int          FS_CTRL_W   = $bits(fs_ctrl_t);
  localparam logic [7:0]  DRV_ON_CODE = 8'h01;

endpackage

// File: rtl/mus_tick_timer.sv
module mus_tick_timer #(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             force_i,
  output logic             refresh_o
);

  localparam int EXT_W = IVL_W + 1;

  logic [IVL_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc;
  logic             periodic_on;
  logic             due;

  assign periodic_on = (ivl_i != '0);
  assign cnt_inc     = {1'b0, cnt_q} + EXT_W'(1);
  // compare with a widened count so a shrunk interval fires on the next tick
  assign due         = tick_i && periodic_on && (cnt_inc >= {1'b0, ivl_i});
  assign refresh_o   = due || force_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (refresh_o || !periodic_on) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_inc[IVL_W-1:0];
    end
  end

  // R2: with a zero interval only a force can refresh
  p_no_auto_r2: assert property (@(posedge clk) disable iff (rst)
    (!periodic_on && !force_i) |-> !refresh_o);

  // R1: a steady interval keeps the count below it
  p_cnt_bounded_r1: assert property (@(posedge clk) disable iff (rst)
    (periodic_on && $stable(ivl_i) && ($past(cnt_q) < ivl_i)) |-> (cnt_q < ivl_i));

  // R3: any force clears the count at the next edge
  p_force_restart_r3: assert property (@(posedge clk) disable iff (rst)
    force_i |=> (cnt_q == '0));

endmodule

// File: rtl/mus_level_bank.sv
module mus_level_bank #(
  parameter int NUM_CH = 4,
  parameter int LVL_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_i,
  input  logic                    clear_i,
  input  logic [NUM_CH*LVL_W-1:0] pend_i,
  output logic [NUM_CH*LVL_W-1:0] act_o
);

  localparam int BUS_W = NUM_CH * LVL_W;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [LVL_W-1:0] lvl_q;

    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        lvl_q <= '0;
      end else if (load_i) begin
        lvl_q <= pend_i[ch*LVL_W +: LVL_W];
      end
    end

    assign act_o[ch*LVL_W +: LVL_W] = lvl_q;
  end

  // R5: a zeroing fault wins over a coincident load
  p_zero_on_fault_r5: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (act_o == '0));

  // R1: without load or clear the levels stay put
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !clear_i) |=> $stable(act_o));

  // R3: a load without clear publishes the sampled pending bus
  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (load_i && !clear_i) |=> (act_o == $past(pend_i)));

  if (BUS_W < 1) begin : g_bad
    initial $error("level bus must be non-empty");
  end

endmodule

// File: rtl/mus_fault_react.sv
module mus_fault_react
  import mus_pkg::*;
#(
  parameter int FCNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_i,
  input  fs_ctrl_t          ctrl_i,
  output logic              zero_o,
  output logic              reboot_o,
  output logic              reenum_o,
  output logic              user_o,
  output logic              exp_o,
  output logic [FCNT_W-1:0] cnt_o
);

  localparam logic [FCNT_W-1:0] CNT_MAX = '1;

  logic [FCNT_W-1:0] cnt_q;

  assign zero_o = fault_i && ctrl_i.zero_out;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reboot_o <= 1'b0;
      reenum_o <= 1'b0;
      user_o   <= 1'b0;
      exp_o    <= 1'b0;
    end else begin
      reboot_o <= fault_i && (ctrl_i.restart == RST_REBOOT);
      reenum_o <= fault_i && (ctrl_i.restart == RST_REENUM);
      user_o   <= fault_i && ctrl_i.user_reinit;
      exp_o    <= fault_i && ctrl_i.exp_reinit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (fault_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + FCNT_W'(1);
    end
  end

  // R6: never both restart kinds at once
  p_one_restart_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reboot_o, reenum_o}));

  // R7: any request pulse is caused by a fault in the previous cycle
  p_req_needs_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (reboot_o || reenum_o || user_o || exp_o) |-> $past(fault_i));

  // R8: one step per fault below the ceiling
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
    (fault_i && (cnt_q != CNT_MAX)) |=> (cnt_q == FCNT_W'($past(cnt_q) + 1'b1)));

  // R8: saturated count stays saturated
  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R8: no fault, no change
  p_cnt_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !fault_i |=> $stable(cnt_q));

endmodule

// File: rtl/motor_update_sched.sv
module motor_update_sched
  import mus_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LVL_W  = 8,
  parameter int IVL_W  = 8,
  parameter int FCNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ms_tick_i,
  input  logic [IVL_W-1:0]        interval_i,
  input  logic                    force_upd_i,
  input  logic [7:0]              drv_enable_i,
  input  logic [4:0]              fs_ctrl_i,
  input  logic                    fault_i,
  input  logic [NUM_CH*LVL_W-1:0] pend_lvl_i,
  output logic [NUM_CH*LVL_W-1:0] act_lvl_o,
  output logic                    drv_en_o,
  output logic                    reboot_req_o,
  output logic                    reenum_req_o,
  output logic                    user_reinit_o,
  output logic                    exp_reinit_o,
  output logic [FCNT_W-1:0]       fault_cnt_o
);

  logic     refresh;
  logic     zero_lvls;
  fs_ctrl_t fs_ctrl;

  assign fs_ctrl = fs_ctrl_t'(fs_ctrl_i);

  mus_tick_timer #(.IVL_W(IVL_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (ms_tick_i),
    .ivl_i     (interval_i),
    .force_i   (force_upd_i),
    .refresh_o (refresh)
  );

  mus_fault_react #(.FCNT_W(FCNT_W)) u_fault (
    .clk      (clk),
    .rst      (rst),
    .fault_i  (fault_i),
    .ctrl_i   (fs_ctrl),
    .zero_o   (zero_lvls),
    .reboot_o (reboot_req_o),
    .reenum_o (reenum_req_o),
    .user_o   (user_reinit_o),
    .exp_o    (exp_reinit_o),
    .cnt_o    (fault_cnt_o)
  );

  mus_level_bank #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .load_i  (refresh),
    .clear_i (zero_lvls),
    .pend_i  (pend_lvl_i),
    .act_o   (act_lvl_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en_o <= 1'b0;
    end else begin
      drv_en_o <= (drv_enable_i == DRV_ON_CODE);
    end
  end

  // R4: the enable output tracks the enable byte one cycle later
  p_en_on_r4: assert property (@(posedge clk) disable iff (rst)
    (drv_enable_i == 8'h01) |=> drv_en_o);

  p_en_off_r4: assert property (@(posedge clk) disable iff (rst)
    (drv_enable_i != 8'h01) |=> !drv_en_o);

  // R5: a hold-mode fault without refresh leaves the levels alone
  p_hold_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (fault_i && !fs_ctrl_i[0] && !force_upd_i && !ms_tick_i) |=> $stable(act_lvl_o));

endmodule

// File: tb/motor_update_sched_tb_top.sv
module motor_update_sched_tb_top;

  localparam int NUM_CH = 3;
  localparam int LVL_W  = 8;
  localparam int IVL_W  = 8;
  localparam int FCNT_W = 3;
  localparam int BUS_W  = NUM_CH * LVL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ms_tick_i = 1'b0;
  logic [IVL_W-1:0] interval_i = '0;
  logic             force_upd_i = 1'b0;
  logic [7:0]       drv_enable_i = 8'h00;
  logic [4:0]       fs_ctrl_i = 5'b0;
  logic             fault_i = 1'b0;
  logic [BUS_W-1:0] pend_lvl_i = '0;
  logic [BUS_W-1:0] act_lvl_o;
  logic             drv_en_o;
  logic             reboot_req_o;
  logic             reenum_req_o;
  logic             user_reinit_o;
  logic             exp_reinit_o;
  logic [FCNT_W-1:0] fault_cnt_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #10 clk = ~clk;

  motor_update_sched #(
    .NUM_CH(NUM_CH), .LVL_W(LVL_W), .IVL_W(IVL_W), .FCNT_W(FCNT_W)
  ) dut_i (
    .clk(clk), .rst(rst), .ms_tick_i(ms_tick_i), .interval_i(interval_i),
    .force_upd_i(force_upd_i), .drv_enable_i(drv_enable_i), .fs_ctrl_i(fs_ctrl_i),
    .fault_i(fault_i), .pend_lvl_i(pend_lvl_i), .act_lvl_o(act_lvl_o),
    .drv_en_o(drv_en_o), .reboot_req_o(reboot_req_o), .reenum_req_o(reenum_req_o),
    .user_reinit_o(user_reinit_o), .exp_reinit_o(exp_reinit_o), .fault_cnt_o(fault_cnt_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus applied at a falling edge, removed at the next
  task automatic step(input logic tk, input logic frc, input logic flt);
    ms_tick_i = tk; force_upd_i = frc; fault_i = flt;
    @(negedge clk);
    ms_tick_i = 1'b0; force_upd_i = 1'b0; fault_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic chk_reqs(input string req, input logic [3:0] exp);
    chk(req, {reboot_req_o, reenum_req_o, user_reinit_o, exp_reinit_o}, exp);
  endtask

  task automatic t_reset;
    chk("R9 levels", act_lvl_o, 0);
    chk("R9 enable", drv_en_o, 0);
    chk_reqs("R9 requests", 4'b0000);
    chk("R9 fault count", fault_cnt_o, 0);
  endtask

  task automatic t_periodic;
    interval_i = 8'd3;
    pend_lvl_i = 24'h30_20_10;
    ticks(2);
    chk("R1 before third tick", act_lvl_o, 0);
    repeat (4) @(negedge clk);
    chk("R1 no tick no change", act_lvl_o, 0);
    ticks(1);
    chk("R1 third tick", act_lvl_o, 24'h30_20_10);
    pend_lvl_i = 24'hA5_5A_C3;
    ticks(2);
    chk("R1 hold between", act_lvl_o, 24'h30_20_10);
    ticks(1);
    chk("R1 next window", act_lvl_o, 24'hA5_5A_C3);
  endtask

  task automatic t_force_only;
    interval_i = 8'd0;
    pend_lvl_i = 24'h01_02_03;
    ticks(10);
    chk("R2 zero interval", act_lvl_o, 24'hA5_5A_C3);
    step(1'b0, 1'b1, 1'b0);
    chk("R3 force loads", act_lvl_o, 24'h01_02_03);
    pend_lvl_i = 24'h44_55_66;
    repeat (3) @(negedge clk);
    chk("R3 force not sticky", act_lvl_o, 24'h01_02_03);
  endtask

  task automatic t_coincide;
    interval_i = 8'd4;
    step(1'b0, 1'b1, 1'b0);
    chk("R3 align force", act_lvl_o, 24'h44_55_66);
    pend_lvl_i = 24'h11_22_33;
    ticks(3);
    chk("R1 before fourth", act_lvl_o, 24'h44_55_66);
    step(1'b1, 1'b1, 1'b0);
    chk("R3 coincident refresh", act_lvl_o, 24'h11_22_33);
    pend_lvl_i = 24'h77_88_99;
    ticks(2);
    step(1'b0, 1'b1, 1'b0);
    chk("R3 mid force", act_lvl_o, 24'h77_88_99);
    pend_lvl_i = 24'hEE_DD_CC;
    ticks(3);
    chk("R3 count restarted", act_lvl_o, 24'h77_88_99);
    ticks(1);
    chk("R3 full window after force", act_lvl_o, 24'hEE_DD_CC);
  endtask

  task automatic t_enable;
    drv_enable_i = 8'h01;
    @(negedge clk);
    chk("R4 enable on", drv_en_o, 1);
    drv_enable_i = 8'h02;
    @(negedge clk);
    chk("R4 other code off", drv_en_o, 0);
    drv_enable_i = 8'h00;
    pend_lvl_i = 24'h0F_F0_5A;
    step(1'b0, 1'b1, 1'b0);
    chk("R4 disabled still refreshes", act_lvl_o, 24'h0F_F0_5A);
    chk("R4 disabled enable low", drv_en_o, 0);
  endtask

  task automatic t_fault_hold;
    fs_ctrl_i = 5'b00000;
    step(1'b0, 1'b0, 1'b1);
    chk("R5 hold levels", act_lvl_o, 24'h0F_F0_5A);
    chk_reqs("R6 code 0 no request", 4'b0000);
    chk("R8 count 1", fault_cnt_o, 1);
  endtask

  task automatic t_fault_zero;
    fs_ctrl_i = 5'b00011;
    @(negedge clk);
    chk_reqs("R7 no fault no pulse", 4'b0000);
    step(1'b0, 1'b0, 1'b1);
    chk("R5 zeroed", act_lvl_o, 0);
    chk_reqs("R6 reboot pulse", 4'b1000);
    chk("R8 count 2", fault_cnt_o, 2);
    @(negedge clk);
    chk_reqs("R6 pulse one cycle", 4'b0000);
    step(1'b0, 1'b1, 1'b0);
    chk("R5 refresh after zero", act_lvl_o, 24'h0F_F0_5A);
    fs_ctrl_i = 5'b00001;
    step(1'b0, 1'b1, 1'b1);
    chk("R5 zero beats refresh", act_lvl_o, 0);
    chk("R8 count 3", fault_cnt_o, 3);
  endtask

  task automatic t_fault_reqs;
    fs_ctrl_i = 5'b11100;
    pend_lvl_i = 24'h12_34_56;
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    chk_reqs("R6 R7 reenum and reinits", 4'b0111);
    chk("R5 hold with reinits", act_lvl_o, 24'h12_34_56);
    @(negedge clk);
    chk_reqs("R7 pulses end", 4'b0000);
    fs_ctrl_i = 5'b00110;
    step(1'b0, 1'b0, 1'b1);
    chk_reqs("R6 code 3 no request", 4'b0000);
    chk("R8 count 5", fault_cnt_o, 5);
    fs_ctrl_i = 5'b01000;
    step(1'b0, 1'b0, 1'b1);
    chk_reqs("R7 user only", 4'b0010);
  endtask

  task automatic t_saturate;
    fs_ctrl_i = 5'b00000;
    step(1'b0, 1'b0, 1'b1);
    chk("R8 count 7", fault_cnt_o, 7);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    chk("R8 saturated", fault_cnt_o, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_force_only();
    t_coincide();
    t_enable();
    t_fault_hold();
    t_fault_zero();
    t_fault_reqs();
    t_saturate();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule